// File: doc/BRIEF.md
# Sticky Device Error Status Register

This block is the 16-bit device status word of a serial-link endpoint. It records four classes of locally detected error (correctable, non-fatal, fatal and unsupported request) as sticky flags. It also shows a live indication that transactions are still outstanding. Each error class arrives as a one-cycle pulse from the receive logic.

Error flags are logged whenever their event occurs. No enable or mask takes part in that decision. An unsupported-request event sets its own flag. It also sets either the fatal flag or the non-fatal flag, chosen by a severity control input.

Software reaches the word through a small configuration access port at a fixed, parameterised byte offset. The default offset is AAh, and the word covers AAh–ABh. A read returns the value in the same cycle. A write takes effect on the next clock edge, and each error flag is cleared by writing 1 to its position.

Top module: `dev_err_status`

## Requirements
- R1: A synchronous, active-high `rst` clears all four error flags, so the word reads 0000h after reset when nothing is pending.
- R2: Bits 15:6 and bit 4 always read 0, and writes of 1 to them change nothing.
- R3: Bit 5 follows `txn_pending` combinationally on every read: 1 while anything is outstanding, 0 otherwise.
- R4: The flags are laid out as bit 0 correctable, bit 1 non-fatal, bit 2 fatal and bit 3 unsupported request. A pulse on the matching event input sets its flag at the next clock edge, and the flag stays set until it is cleared.
- R5: A write with `cfg_be[0]`=1 to an address whose bits [11:1] match the offset clears, at the next edge, every flag whose data bit (3:0) is 1. Writing 0, a write with `cfg_be[0]`=0, or a write to another address leaves the flags unchanged.
- R6: An unsupported-request pulse sets bit 3. It also sets bit 2 when `unsup_is_fatal`=1, or bit 1 when `unsup_is_fatal`=0.
- R7: When an event and a write-1-to-clear hit the same flag in the same cycle, the flag is set after that edge.
- R8: `cfg_rdata` carries the register value in the same cycle as `cfg_rd`=1 with a matching address. Otherwise it is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 12 | Configuration byte address |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 2 | Byte enables for the two bytes of the word |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data, same cycle |
| ev_corr | input | 1 | Correctable error pulse |
| ev_nonfatal | input | 1 | Non-fatal error pulse |
| ev_fatal | input | 1 | Fatal error pulse |
| ev_unsup | input | 1 | Unsupported request pulse |
| unsup_is_fatal | input | 1 | Severity control for unsupported requests |
| txn_pending | input | 1 | Live transaction-pending level |

## Verification
The functions that can collide are the hardware setting of a flag and the software clear of the same flag. The bench raises an event pulse in the very cycle that a write of 1 targets that bit. This is done both directly and through an unsupported request routed onto the fatal and non-fatal flags. The bench then reads the word on the following cycle and expects the flag to still be set. A cycle-level reference model is compared on every clock, so a clear that wins the collision, or a flag that is wrongly routed, shows up as a mismatch.

// File: rtl/dsts_pkg.sv
package dsts_pkg;
   localparam int unsigned REG_W    = 16;
   localparam int unsigned NUM_ERR  = 4;
   localparam int unsigned BIT_CORR = 0;
   localparam int unsigned BIT_NF   = 1;
   localparam int unsigned BIT_FAT  = 2;
   localparam int unsigned BIT_UR   = 3;
   localparam int unsigned BIT_PEND = 5;

   typedef struct packed {
      logic ur;
      logic fatal;
      logic nonfatal;
      logic corr;
   } err_vec_t;
endpackage

// File: rtl/dsts_sev_route.sv
module dsts_sev_route
   import dsts_pkg::*;
(
   input  logic     ev_corr,
   input  logic     ev_nonfatal,
   input  logic     ev_fatal,
   input  logic     ev_unsup,
   input  logic     unsup_is_fatal,
   output err_vec_t set_vec
);
   always_comb begin
      set_vec.corr     = ev_corr;
      set_vec.nonfatal = ev_nonfatal | (ev_unsup & ~unsup_is_fatal);
      set_vec.fatal    = ev_fatal    | (ev_unsup &  unsup_is_fatal);
      set_vec.ur       = ev_unsup;
   end
endmodule

// File: rtl/dsts_cfg_port.sv
module dsts_cfg_port
   import dsts_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned REG_OFFSET = 'hAA
)(
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic               cfg_rd,
   input  logic               cfg_wr,
   input  logic [1:0]         cfg_be,
   input  logic [REG_W-1:0]   cfg_wdata,
   output logic               rd_act,
   output logic [NUM_ERR-1:0] clr_mask
);
   localparam logic [ADDR_W-1:0] OFF_A = REG_OFFSET[ADDR_W-1:0];

   generate
      if (REG_OFFSET % 2 != 0) begin : g_bad_align
         $error("dsts_cfg_port: REG_OFFSET must be 2-byte aligned");
      end
      if (ADDR_W < 2 || ADDR_W > 31 || REG_OFFSET >= (1 << ADDR_W)) begin : g_bad_range
         $error("dsts_cfg_port: REG_OFFSET does not fit ADDR_W");
      end
   endgenerate

   logic hit;
   assign hit      = (cfg_addr[ADDR_W-1:1] == OFF_A[ADDR_W-1:1]);
   assign rd_act   = cfg_rd & hit;
   assign clr_mask = (cfg_wr && hit && cfg_be[0]) ? cfg_wdata[NUM_ERR-1:0] : '0;
endmodule

// File: rtl/dsts_sticky.sv
module dsts_sticky #(
   parameter bit SET_WINS = 1'b1
)(
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   generate
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= set_i | (q & ~clr_i);
         end
         a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
            (set_i && clr_i) |=> q);
         a_r4_set_lands: assert property (@(posedge clk) disable iff (rst)
            set_i |=> q);
      end else begin : g_clr_wins
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= (q | set_i) & ~clr_i;
         end
      end
   endgenerate

   a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !set_i) |=> !q);
   a_r4_holds: assert property (@(posedge clk) disable iff (rst)
      (!set_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/dev_err_status.sv
module dev_err_status
   import dsts_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned REG_OFFSET = 'hAA,
   parameter bit          SET_WINS   = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_rd,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_be,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              ev_corr,
   input  logic              ev_nonfatal,
   input  logic              ev_fatal,
   input  logic              ev_unsup,
   input  logic              unsup_is_fatal,
   input  logic              txn_pending
);
   err_vec_t           set_vec;
   logic [NUM_ERR-1:0] clr_mask;
   logic [NUM_ERR-1:0] err_q;
   logic               rd_act;
   logic [REG_W-1:0]   reg_val;

   dsts_sev_route u_route (
      .ev_corr        (ev_corr),
      .ev_nonfatal    (ev_nonfatal),
      .ev_fatal       (ev_fatal),
      .ev_unsup       (ev_unsup),
      .unsup_is_fatal (unsup_is_fatal),
      .set_vec        (set_vec)
   );

   dsts_cfg_port #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_port (
      .cfg_addr  (cfg_addr),
      .cfg_rd    (cfg_rd),
      .cfg_wr    (cfg_wr),
      .cfg_be    (cfg_be),
      .cfg_wdata (cfg_wdata),
      .rd_act    (rd_act),
      .clr_mask  (clr_mask)
   );

   generate
      for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
         dsts_sticky #(.SET_WINS(SET_WINS)) u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_vec[i]),
            .clr_i (clr_mask[i]),
            .q     (err_q[i])
         );
      end
   endgenerate

   always_comb begin
      reg_val                   = '0;
      reg_val[NUM_ERR-1:0]      = err_q;
      reg_val[BIT_PEND]         = txn_pending;
   end

   assign cfg_rdata = rd_act ? reg_val : '0;

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (err_q == '0));
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      (cfg_rdata[REG_W-1:6] == '0) && (cfg_rdata[4] == 1'b0));
   a_r3_pending_live: assert property (@(posedge clk) disable iff (rst)
      (cfg_rd && cfg_rdata != '0) |-> (cfg_rdata[BIT_PEND] == txn_pending));
   a_r6_ur_fatal: assert property (@(posedge clk) disable iff (rst)
      (ev_unsup && unsup_is_fatal) |=> (err_q[BIT_FAT] && err_q[BIT_UR]));
   a_r6_ur_nonfatal: assert property (@(posedge clk) disable iff (rst)
      (ev_unsup && !unsup_is_fatal) |=> (err_q[BIT_NF] && err_q[BIT_UR]));
   a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !cfg_rd |-> (cfg_rdata == '0));
endmodule

// File: tb/dev_err_status_bench.sv
module dev_err_status_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic [11:0] cfg_addr;
   logic        cfg_rd, cfg_wr;
   logic [1:0]  cfg_be;
   logic [15:0] cfg_wdata;
   logic [15:0] cfg_rdata;
   logic        ev_corr, ev_nonfatal, ev_fatal, ev_unsup, unsup_is_fatal, txn_pending;

   int          n_run  = 0;
   int          n_fail = 0;
   logic [3:0]  mdl    = 4'h0;
   bit          done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dev_err_status u_dev_err_status (
      .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .ev_corr(ev_corr), .ev_nonfatal(ev_nonfatal), .ev_fatal(ev_fatal),
      .ev_unsup(ev_unsup), .unsup_is_fatal(unsup_is_fatal), .txn_pending(txn_pending)
   );

   function automatic bit addr_hit(input logic [11:0] a);
      return a[11:1] == 11'h055;
   endfunction

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("[TB] FAIL %s: got %04h expected %04h", tag, got, exp);
      end
   endtask

   task automatic idle();
      rst = 0; cfg_addr = 12'h0AA; cfg_rd = 1; cfg_wr = 0; cfg_be = 2'b00;
      cfg_wdata = 16'h0; ev_corr = 0; ev_nonfatal = 0; ev_fatal = 0;
      ev_unsup = 0; unsup_is_fatal = 0;
   endtask

   // Drives the current inputs for one cycle: checks the same-cycle read against
   // the model, then advances the model across the clock edge.
   task automatic cyc(input string tag);
      logic [15:0] exp;
      logic [3:0]  set, clr;
      #1;
      exp = 16'h0;
      if (cfg_rd && addr_hit(cfg_addr)) exp = {10'h0, txn_pending, 1'b0, mdl};
      check(tag, cfg_rdata, exp);
      set = {ev_unsup, ev_fatal | (ev_unsup & unsup_is_fatal),
             ev_nonfatal | (ev_unsup & ~unsup_is_fatal), ev_corr};
      clr = (cfg_wr && addr_hit(cfg_addr) && cfg_be[0]) ? cfg_wdata[3:0] : 4'h0;
      @(posedge clk);
      if (rst) mdl = 4'h0;
      else     mdl = (mdl & ~clr) | set;
      @(negedge clk);
      idle();
   endtask

   task automatic wr(input logic [11:0] a, input logic [1:0] be, input logic [15:0] d);
      cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("[TB] FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      idle(); txn_pending = 0; rst = 1;
      @(negedge clk); rst = 1; cyc("R1 reset");
      rst = 1; ev_corr = 1; ev_fatal = 1; cyc("R1 reset");
      cyc("R1 reset value 0000h");
      // R4 single events
      ev_corr = 1;     cyc("R4 corr");
      cyc("R4 corr sticky");
      ev_nonfatal = 1; cyc("R4 nonfatal");
      ev_fatal = 1;    cyc("R4 fatal");
      cyc("R4 all held");
      // R8 read with other address / no strobe
      cfg_addr = 12'h0A8; cyc("R8 miss addr");
      cfg_rd = 0;         cyc("R8 no strobe");
      cfg_addr = 12'h0AB; cyc("R8 upper byte hit");
      // R3 pending
      txn_pending = 1; cyc("R3 pending high");
      txn_pending = 0; cyc("R3 pending low");
      txn_pending = 1;
      // R5 clears
      wr(12'h0AA, 2'b01, 16'h0001); cyc("R5 clear corr");
      cyc("R5 after clear");
      wr(12'h0AA, 2'b01, 16'h0000); cyc("R5 write zero");
      wr(12'h0AA, 2'b10, 16'h00FF); cyc("R5 be0 low");
      wr(12'h0A8, 2'b11, 16'h000F); cyc("R5 other addr");
      cyc("R5 state kept");
      // R2 reserved writes
      wr(12'h0AA, 2'b11, 16'hFFF0); cyc("R2 reserved write");
      cyc("R2 reserved read");
      wr(12'h0AA, 2'b11, 16'hFFFF); cyc("R5 clear all");
      cyc("R5 all cleared");
      // R6 routing
      ev_unsup = 1; unsup_is_fatal = 0; cyc("R6 ur nonfatal");
      cyc("R6 ur nonfatal read");
      wr(12'h0AA, 2'b01, 16'h000F); cyc("R5 clear");
      ev_unsup = 1; unsup_is_fatal = 1; cyc("R6 ur fatal");
      cyc("R6 ur fatal read");
      // R7 collisions
      wr(12'h0AA, 2'b01, 16'h0004); ev_fatal = 1; cyc("R7 fatal set vs clear");
      cyc("R7 fatal kept");
      wr(12'h0AA, 2'b01, 16'h000F); ev_unsup = 1; unsup_is_fatal = 0;
      cyc("R7 ur routed vs clear");
      cyc("R7 ur and nonfatal kept");
      wr(12'h0AB, 2'b01, 16'h0003); ev_corr = 1; cyc("R7 corr vs clear");
      cyc("R7 corr kept");
      // mixed pattern sweep
      for (int k = 0; k < 32; k++) begin
         ev_corr = k[0]; ev_nonfatal = k[1]; ev_fatal = k[2]; ev_unsup = k[3];
         unsup_is_fatal = k[4]; txn_pending = k[1] ^ k[3];
         if (k % 3 == 0) wr(12'h0AA, 2'b01, 16'(k * 5));
         cyc("R4 sweep");
      end
      // R1 reset mid-run
      ev_fatal = 1; cyc("R4 pre reset");
      rst = 1; cyc("R1 mid reset");
      txn_pending = 0; cyc("R1 after reset");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule